// File: doc/BRIEF.md
# Coded-Bit Soft Demapper

This block turns one received two-dimensional symbol into soft information for an iterative decoder. Each symbol arrives as two equalized amplitudes, each carrying one coordinate of a 16-level grid that a Tomlinson-style precoder may have pushed outside its nominal ±15 span. The block undoes the offset and the 45-degree rotation of the double-square constellation to recover two folded coordinates. It reduces each coordinate modulo 4 and evaluates a piecewise-linear log-likelihood kernel for the four Gray-labelled code bits. The kernel output is weighted by an inverse noise variance supplied alongside the data.

The kernel is the max-log form of the bit metric. It is a triangle wave with slopes of ±1 that peaks at +1 at 0.5 and reaches −1 at 2.5, with zero crossings at 1.5 and 3.5. The whole datapath uses additions, bit masking and one multiply. The result saturates symmetrically to a 16-bit signed message with 5 fractional bits. A fixed three-stage pipeline carries a valid flag with the data.

Top module: `llr_demapper`

## Requirements
- R1: Input amplitudes `rx_a` and `rx_b` are signed with 5 fractional bits. The block forms the folded coordinates u = (rx_a − rx_b)/4 and v = (rx_a + rx_b + 30)/4. This equals offsetting each sample by +15, halving it, and rotating by the matrix 0.5·[[1,−1],[1,1]].
- R2: Each kernel argument is a floor modulo 4, so negative and large amplitudes fold correctly. Lane `llr_c1` uses u mod 4, `llr_c2` uses (u+1) mod 4, `llr_c3` uses v mod 4 and `llr_c4` uses (v+1) mod 4.
- R3: The kernel k(t) over 0 ≤ t < 4 equals t+0.5 for t < 0.5, 1.5−t for 0.5 ≤ t < 2.5, and t−3.5 for t ≥ 2.5. It is exact at the breakpoints: k(0.5)=1, k(1.5)=0, k(2.5)=−1 and k(3.5)=0.
- R4: `inv_noise` is unsigned with 4 fractional bits. Each LLR equals floor(k·inv_noise·32) as a signed integer with 5 fractional bits. An `inv_noise` of 0 gives all-zero LLRs.
- R5: Any LLR whose value would exceed 32767 in magnitude is clamped to +32767 or −32767. The code −32768 never appears.
- R6: `out_valid` and the four LLRs appear exactly 3 clock edges after the edge that samples `in_valid` high. `out_valid` is low in every other cycle.
- R7: A positive LLR means bit 0. For a noiseless point with code label x1 = {p,q,c1,c1^c2} and x2 = {r,s,c3,c4^c3}, each LLR equals +inv_noise when its bit is 0 and −inv_noise when it is 1. Here x1 and x2 are 4-bit labels with the MSB first, and the transmitted amplitudes are 2·((x1+x2) mod 16)−15 and 2·((x2−x1) mod 16)−15.
- R8: While `rst` is high on a clock edge, `out_valid` and all LLRs are cleared to 0 from that edge.
- R9: Adding ±32 to either amplitude, as a precoder extension does, leaves all four LLRs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input symbol qualifier |
| rx_a | input | 14 | First equalized amplitude, signed, 5 fractional bits |
| rx_b | input | 14 | Second equalized amplitude, signed, 5 fractional bits |
| inv_noise | input | 16 | Inverse noise variance, unsigned, 4 fractional bits |
| out_valid | output | 1 | LLR qualifier |
| llr_c1 | output | 16 | LLR of code bit 1, signed, 5 fractional bits |
| llr_c2 | output | 16 | LLR of code bit 2 |
| llr_c3 | output | 16 | LLR of code bit 3 |
| llr_c4 | output | 16 | LLR of code bit 4 |

## Verification
The sign assertions assume that `inv_noise` is stable for the cycle it is sampled, and that `in_valid` is held low during reset so the latency property starts from an empty pipeline. The stimulus drives every input on the falling edge and keeps amplitudes well inside the 14-bit range, including the ±32 extensions. A full sweep of the 256 label pairs checks the sign convention on noiseless points, a fold sweep covers fractional and negative amplitudes, and targeted points land exactly on each kernel breakpoint and on the saturation limits.

// File: rtl/llr_demap_pkg.sv
package llr_demap_pkg;
  localparam int LANES   = 4;   // c1, c2, c3, c4
  localparam int PAM_MAX = 15;  // nominal outer level of each 16-PAM axis
endpackage

// File: rtl/llr_fold.sv
// Stage 1: offset, rotation and modulo-4 fold of both coordinates.
module llr_fold #(
  parameter int IN_W    = 14,
  parameter int IN_FRAC = 5,
  parameter int T_FRAC  = IN_FRAC + 2,
  parameter int T_W     = T_FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  rx_a,
  input  logic signed [IN_W-1:0]  rx_b,
  output logic [T_W-1:0]          t_q [llr_demap_pkg::LANES]
);
  import llr_demap_pkg::*;

  // (a+15)/2 and (b+15)/2 rotated by 0.5*[[1,-1],[1,1]] gives (a-b)/4 and
  // (a+b+30)/4; the divide by 4 moves the binary point by two places, so
  // the integer code is unchanged and the modulo is a mask to T_W bits.
  localparam logic [T_W-1:0] OFFS = T_W'((2 * PAM_MAX) << IN_FRAC);
  localparam logic [T_W-1:0] ONE  = T_W'(1 << T_FRAC);

  logic [T_W-1:0] a_lo, b_lo, u_mod, v_mod;

  always_comb begin
    a_lo  = rx_a[T_W-1:0];
    b_lo  = rx_b[T_W-1:0];
    u_mod = a_lo - b_lo;
    v_mod = a_lo + b_lo + OFFS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LANES; i++) t_q[i] <= '0;
    end else begin
      t_q[0] <= u_mod;
      t_q[1] <= u_mod + ONE;
      t_q[2] <= v_mod;
      t_q[3] <= v_mod + ONE;
    end
  end
endmodule

// File: rtl/llr_kernel.sv
// Stage 2: piecewise-linear bit metric over one modulo-4 period.
module llr_kernel #(
  parameter int T_FRAC = 7,
  parameter int T_W    = T_FRAC + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [T_W-1:0]        t_in,
  output logic signed [T_W-1:0] f_q
);
  localparam int HALF = 1 << (T_FRAC - 1);
  localparam logic [T_W-1:0] BRK_LO = T_W'(HALF);      // 0.5
  localparam logic [T_W-1:0] BRK_HI = T_W'(5 * HALF);  // 2.5
  localparam logic [T_W-1:0] C_H    = T_W'(HALF);
  localparam logic [T_W-1:0] C_3H   = T_W'(3 * HALF);
  localparam logic [T_W-1:0] C_7H   = T_W'(7 * HALF);
  localparam logic signed [T_W-1:0] K_MAX = T_W'(2 * HALF);

  // Every segment result lies within +-1.0, which fits T_W signed bits, so
  // wrap-around arithmetic in T_W bits yields the exact two's complement.
  logic [T_W-1:0] seg;

  always_comb begin
    if (t_in < BRK_LO)      seg = t_in + C_H;
    else if (t_in < BRK_HI) seg = C_3H - t_in;
    else                    seg = t_in - C_7H;
  end

  always_ff @(posedge clk) begin
    if (rst) f_q <= '0;
    else     f_q <= $signed(seg);
  end

  AST_KERNEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (f_q <= K_MAX) && (f_q >= -K_MAX)); // R3
endmodule

// File: rtl/llr_scale_sat.sv
// Stage 3: noise weighting, requantization and symmetric saturation.
module llr_scale_sat #(
  parameter int K_W     = 9,
  parameter int K_FRAC  = 7,
  parameter int SC_W    = 16,
  parameter int SC_FRAC = 4,
  parameter int LLR_W   = 16,
  parameter int LLR_FRAC = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [K_W-1:0]   f_in,
  input  logic [SC_W-1:0]         sc_in,
  output logic signed [LLR_W-1:0] llr_q
);
  localparam int PW = K_W + SC_W + 1;
  localparam int SH = K_FRAC + SC_FRAC - LLR_FRAC;
  localparam logic signed [PW-1:0] POS_LIM = PW'((1 << (LLR_W - 1)) - 1);
  localparam logic signed [PW-1:0] NEG_LIM = -POS_LIM;
  localparam logic signed [LLR_W-1:0] MOST_NEG = {1'b1, {(LLR_W-1){1'b0}}};

  logic signed [PW-1:0] prod, shifted;

  always_comb begin
    prod    = PW'(f_in) * $signed({{(K_W){1'b0}}, sc_in});
    shifted = prod >>> SH;
  end

  always_ff @(posedge clk) begin
    if (rst)                    llr_q <= '0;
    else if (shifted > POS_LIM) llr_q <= POS_LIM[LLR_W-1:0];
    else if (shifted < NEG_LIM) llr_q <= NEG_LIM[LLR_W-1:0];
    else                        llr_q <= shifted[LLR_W-1:0];
  end

  AST_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
    (f_in >= 0) |=> (llr_q >= 0)); // R7
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
    ((f_in < 0) && (sc_in != '0)) |=> (llr_q < 0)); // R7
  AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (sc_in == '0) |=> (llr_q == '0)); // R4
  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
    llr_q != MOST_NEG); // R5
endmodule

// File: rtl/llr_demapper.sv
module llr_demapper #(
  parameter int IN_W     = 14,
  parameter int IN_FRAC  = 5,
  parameter int SC_W     = 16,
  parameter int SC_FRAC  = 4,
  parameter int LLR_W    = 16,
  parameter int LLR_FRAC = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  rx_a,
  input  logic signed [IN_W-1:0]  rx_b,
  input  logic [SC_W-1:0]         inv_noise,
  output logic                    out_valid,
  output logic signed [LLR_W-1:0] llr_c1,
  output logic signed [LLR_W-1:0] llr_c2,
  output logic signed [LLR_W-1:0] llr_c3,
  output logic signed [LLR_W-1:0] llr_c4
);
  import llr_demap_pkg::*;

  localparam int T_FRAC = IN_FRAC + 2;
  localparam int T_W    = T_FRAC + 2;
  localparam int DEPTH  = 3;

  logic [T_W-1:0]          t_s1 [LANES];
  logic signed [T_W-1:0]   f_s2 [LANES];
  logic signed [LLR_W-1:0] llr_s3 [LANES];
  logic [SC_W-1:0]         sc_s1, sc_s2;
  logic [DEPTH-1:0]        vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_s1 <= '0;
      sc_s2 <= '0;
      vld   <= '0;
    end else begin
      sc_s1 <= inv_noise;
      sc_s2 <= sc_s1;
      vld   <= {vld[DEPTH-2:0], in_valid};
    end
  end

  llr_fold #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .T_FRAC(T_FRAC), .T_W(T_W)
  ) u_fold (
    .clk(clk), .rst(rst), .rx_a(rx_a), .rx_b(rx_b), .t_q(t_s1)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    llr_kernel #(.T_FRAC(T_FRAC), .T_W(T_W)) u_kern (
      .clk(clk), .rst(rst), .t_in(t_s1[g]), .f_q(f_s2[g])
    );
    llr_scale_sat #(
      .K_W(T_W), .K_FRAC(T_FRAC), .SC_W(SC_W), .SC_FRAC(SC_FRAC),
      .LLR_W(LLR_W), .LLR_FRAC(LLR_FRAC)
    ) u_scale (
      .clk(clk), .rst(rst), .f_in(f_s2[g]), .sc_in(sc_s2), .llr_q(llr_s3[g])
    );
  end

  assign out_valid = vld[DEPTH-1];
  assign llr_c1    = llr_s3[0];
  assign llr_c2    = llr_s3[1];
  assign llr_c3    = llr_s3[2];
  assign llr_c4    = llr_s3[3];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3)); // R6
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid); // R6
endmodule

// File: tb/llr_demapper_bench.sv
module llr_demapper_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [13:0] rx_a = '0;
  logic signed [13:0] rx_b = '0;
  logic [15:0] inv_noise = '0;
  logic out_valid;
  logic signed [15:0] llr_c1, llr_c2, llr_c3, llr_c4;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  llr_demapper u_llr_demapper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rx_a(rx_a), .rx_b(rx_b),
    .inv_noise(inv_noise), .out_valid(out_valid),
    .llr_c1(llr_c1), .llr_c2(llr_c2), .llr_c3(llr_c3), .llr_c4(llr_c4)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Kernel of R3, argument in units of 1/128, result in units of 1/128.
  function automatic int kern(input int t);
    if (t < 64)       return t + 64;
    else if (t < 320) return 192 - t;
    else              return t - 448;
  endfunction

  // R1, R2, R4, R5 computed from the requirement arithmetic.
  function automatic int model(input int a, input int b, input int sc, input int lane);
    int x, p, q;
    x = (lane < 2) ? (a - b) : (a + b + 960);
    if (lane % 2 == 1) x = x + 128;
    p = kern(x & 511) * sc;
    q = p >>> 6;
    if (q > 32767)  q = 32767;
    if (q < -32767) q = -32767;
    return q;
  endfunction

  function automatic int lane_out(input int lane);
    case (lane)
      0: return int'(llr_c1);
      1: return int'(llr_c2);
      2: return int'(llr_c3);
      default: return int'(llr_c4);
    endcase
  endfunction

  // Drive at a falling edge; result is stable after the third rising edge.
  task automatic apply(input int a, input int b, input int sc);
    rx_a = 14'(a); rx_b = 14'(b); inv_noise = 16'(sc); in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_model(input string req, input int a, input int b, input int sc);
    apply(a, b, sc);
    for (int l = 0; l < 4; l++) check(req, lane_out(l), model(a, b, sc, l));
  endtask

  initial begin
    #(10ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check("R8 out_valid", int'(out_valid), 0);
    check("R8 llr_c1", int'(llr_c1), 0);
    check("R8 llr_c4", int'(llr_c4), 0);

    // R6: valid emerges on the third edge only
    rx_a = 14'sd100; rx_b = -14'sd40; inv_noise = 16'd50; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R6 stage1", int'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    check("R6 stage2", int'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    check("R6 stage3", int'(out_valid), 1);
    check("R6 data", int'(llr_c1), model(100, -40, 50, 0));
    @(posedge clk); @(negedge clk);
    check("R6 single pulse", int'(out_valid), 0);

    // R7, R2, R9: noiseless points from the mapper, with extensions
    for (int x1 = 0; x1 < 16; x1++) begin
      for (int x2 = 0; x2 < 16; x2++) begin
        for (int e = 0; e < 3; e++) begin
          int y1, y2, a, b, bits[4];
          y1 = (x1 + x2) % 16;
          y2 = (x2 - x1 + 16) % 16;
          a = (2 * y1 - 15) * 32;
          b = (2 * y2 - 15) * 32;
          if (e == 1) a = a + 32 * 32;
          if (e == 2) b = b - 32 * 32;
          bits[0] = (x1 >> 1) & 1;
          bits[1] = ((x1 >> 1) ^ x1) & 1;
          bits[2] = (x2 >> 1) & 1;
          bits[3] = ((x2 >> 1) ^ x2) & 1;
          apply(a, b, 100);
          for (int l = 0; l < 4; l++)
            check((e == 0) ? "R7 noiseless sign" : "R9 extended point",
                  lane_out(l), (bits[l] == 0) ? 100 : -100);
        end
      end
    end

    // R3: exact values at the breakpoints (lane c1 with rx_b = 0)
    apply(64, 0, 256);  check("R3 k(0.5)", int'(llr_c1), 512);
    apply(192, 0, 256); check("R3 k(1.5)", int'(llr_c1), 0);
    apply(320, 0, 256); check("R3 k(2.5)", int'(llr_c1), -512);
    apply(448, 0, 256); check("R3 k(3.5)", int'(llr_c1), 0);
    apply(0, 0, 256);   check("R3 k(0) c1", int'(llr_c1), 256);
    check("R3 k(1) c2", int'(llr_c2), 256);

    // R4: zero weight
    run_model("R4 zero weight", 77, -13, 0);
    check("R4 zero c3", int'(llr_c3), 0);

    // R5: saturation at both ends
    apply(64, 0, 65535);  check("R5 positive clamp", int'(llr_c1), 32767);
    apply(320, 0, 65535); check("R5 negative clamp", int'(llr_c1), -32767);

    // R1, R2, R4: fold sweep with fractional and negative amplitudes
    for (int i = 0; i < 480; i++) begin
      int a, b, sc;
      a = -4096 + i * 17;
      b = ((i * 131) % 8192) - 4096;
      case (i % 6)
        0: sc = 1;
        1: sc = 3;
        2: sc = 77;
        3: sc = 1000;
        4: sc = 65535;
        default: sc = 12345;
      endcase
      run_model("R1 fold sweep", a, b, sc);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule